// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps one DRAM bank alive by issuing CAS-before-RAS refresh cycles on behalf of a memory controller. An interval timer, reloaded from a programmable period, produces refresh ticks. Each tick adds one entry to a small pending count. The scheduler raises a request toward the access sequencer. When the sequencer grants the bus and reports no normal access in flight, the scheduler drives one complete strobe sequence: CAS alone, then CAS with RAS, then precharge with both strobes high.

Ticks that arrive while the bus is held by normal traffic are not lost. They pile up in the pending count, up to seven, and are later served one after another. A tick that finds the count full is discarded and latches a sticky overflow flag. Two resets exist. The power-on reset clears everything. The external reset is the board-level reset: refresh runs straight through it, and it only clears the overflow flag. Dropping the enable clears the backlog and freezes the timer.

Top module: `cbrRefreshSched`

## Requirements
- R1: In every refresh cycle casN goes low at least one clock before rasN goes low. While rasN is low, casN is also low. Both strobes return high on the same clock edge.
- R2: While refreshEn is high, a refresh tick occurs every periodCfg clocks, with periodCfg values of 0 and 1 both meaning every clock. The first tick comes periodCfg clocks after the enable is first sampled high. Each tick raises pendingCnt by one.
- R3: pendingCnt never exceeds 7. A tick that finds pendingCnt at 7, in a clock where no cycle completes, is dropped and sets overflow. overflow then stays high until a reset clears it.
- R4: A refresh cycle starts only from idle, and only in a clock where refreshEn is high, pendingCnt is nonzero, refGrant is high and busBusy is low. refReq is high exactly when refreshEn is high, pendingCnt is nonzero and no cycle is active.
- R5: A cycle spends max(casSetupCfg,1) clocks in CAS setup (casN low, rasN high), max(rasWidthCfg,1) clocks with both strobes low, and max(prechargeCfg,1) clocks of precharge with both high. refActive is high for this whole span. Back-to-back cycles are separated by exactly one idle clock.
- R6: pendingCnt falls by one at the clock edge that ends the precharge. If a tick lands on the same edge, the count is unchanged.
- R7: Holding extRst high clears overflow. It does not affect the timer, pendingCnt or the strobe sequence, so pending refreshes are still served while extRst is high.
- R8: With refreshEn low, pendingCnt is cleared, the timer is held at zero and no new cycle starts. A cycle already running completes normally.
- R9: While porRstN is low, rasN and casN are high, and refReq, refActive, pendingCnt and overflow are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| extRst | input | 1 | External reset; clears only the overflow flag |
| refreshEn | input | 1 | Refresh enable |
| periodCfg | input | PERIOD_W | Refresh interval in clocks |
| casSetupCfg | input | TIME_W | Clocks of CAS before RAS |
| rasWidthCfg | input | TIME_W | Clocks with RAS low |
| prechargeCfg | input | TIME_W | Clocks of precharge after the pulse |
| busBusy | input | 1 | Access sequencer has a normal access in flight |
| refGrant | input | 1 | Access sequencer grants the bus for refresh |
| refReq | output | 1 | Refresh wanted and none running |
| refActive | output | 1 | A refresh cycle owns the bus |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| pendingCnt | output | PEND_W | Outstanding refresh count |
| overflow | output | 1 | Sticky flag for a dropped refresh tick |

## Verification
The bench builds the block with its default parameters: a 16-bit period field, 4-bit phase timers and a pending limit of seven. It programs short periods of 1 to 40 clocks, so the backlog reaches saturation and overflow within a few dozen clocks. Zero timing values reach the minimum one-clock phases, and a period of one fires a tick on every clock. Random grant and busy patterns push cycle starts against ticks and completions landing on the same edge. Directed steps cover disabling in the middle of a cycle and draining the backlog while extRst is held.

// File: rtl/cbrRefreshPkg.sv
package cbrRefreshPkg;

  // Phase of the refresh strobe sequence
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CAS  = 2'd1,
    PH_RAS  = 2'd2,
    PH_PRE  = 2'd3
  } phaseT;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCas;
    logic loadRas;
    logic loadPre;
    logic cycleDone;
  } ctlStrobeT;

endpackage

// File: rtl/cbrRefreshData.sv
module cbrRefreshData
  import cbrRefreshPkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int TIME_W   = 4,
  parameter int MAX_PEND = 7,
  localparam int PEND_W  = $clog2(MAX_PEND + 1)
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic                extRst,
  input  logic                refreshEn,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [TIME_W-1:0]   casSetupCfg,
  input  logic [TIME_W-1:0]   rasWidthCfg,
  input  logic [TIME_W-1:0]   prechargeCfg,
  input  ctlStrobeT           strobe,
  output logic [PEND_W-1:0]   pendingCnt,
  output logic                pendingNz,
  output logic                phaseDone,
  output logic                overflow
);

  localparam logic [PEND_W-1:0] PEND_MAX = PEND_W'(MAX_PEND);

  // Interval timer
  logic [PERIOD_W-1:0] timerCnt;
  logic [PERIOD_W:0]   timerNext;
  logic                tick;

  assign timerNext = {1'b0, timerCnt} + 1'b1;
  assign tick      = refreshEn && (timerNext >= {1'b0, periodCfg});

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)                timerCnt <= '0;
    else if (!refreshEn || tick) timerCnt <= '0;
    else                         timerCnt <= timerNext[PERIOD_W-1:0];
  end

  // Phase length counter: a setting of zero is treated as one clock
  function automatic logic [TIME_W-1:0] phaseLen(input logic [TIME_W-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  logic [TIME_W-1:0] phaseCnt;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)              phaseCnt <= '0;
    else if (strobe.loadCas)   phaseCnt <= phaseLen(casSetupCfg);
    else if (strobe.loadRas)   phaseCnt <= phaseLen(rasWidthCfg);
    else if (strobe.loadPre)   phaseCnt <= phaseLen(prechargeCfg);
    else if (phaseCnt != '0)   phaseCnt <= phaseCnt - 1'b1;
  end

  assign phaseDone = (phaseCnt == '0);

  // Pending stack of missed refreshes
  logic decOk, incOk, dropTick;

  assign pendingNz = (pendingCnt != '0);
  assign decOk     = strobe.cycleDone && pendingNz;
  assign incOk     = tick && ((pendingCnt != PEND_MAX) || decOk);
  assign dropTick  = tick && !incOk;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)              pendingCnt <= '0;
    else if (!refreshEn)       pendingCnt <= '0;
    else if (incOk && !decOk)  pendingCnt <= pendingCnt + 1'b1;
    else if (decOk && !incOk)  pendingCnt <= pendingCnt - 1'b1;
  end

  // Sticky overflow: a drop outranks the external reset
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)      overflow <= 1'b0;
    else if (dropTick) overflow <= 1'b1;
    else if (extRst)   overflow <= 1'b0;
  end

  // Checks
  AST_PEND_STEP: assert property (@(posedge clk) disable iff (!porRstN)
    (refreshEn && $past(refreshEn)) |->
      (pendingCnt == $past(pendingCnt)) ||
      ({1'b0, pendingCnt} == {1'b0, $past(pendingCnt)} + 1'b1) ||
      ({1'b0, $past(pendingCnt)} == {1'b0, pendingCnt} + 1'b1)); // R6

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!porRstN)
    (overflow && !extRst) |=> overflow); // R3

  AST_EXTRST_KEEPS_PEND: assert property (@(posedge clk) disable iff (!porRstN)
    (extRst && refreshEn && !tick && !strobe.cycleDone) |=>
      (pendingCnt == $past(pendingCnt))); // R7

endmodule

// File: rtl/cbrRefreshCtl.sv
module cbrRefreshCtl
  import cbrRefreshPkg::*;
(
  input  logic      clk,
  input  logic      porRstN,
  input  logic      refreshEn,
  input  logic      pendingNz,
  input  logic      phaseDone,
  input  logic      refGrant,
  input  logic      busBusy,
  output ctlStrobeT strobe,
  output logic      refReq,
  output logic      refActive,
  output logic      rasN,
  output logic      casN
);

  phaseT phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    unique case (phase)
      PH_IDLE: if (refreshEn && pendingNz && refGrant && !busBusy) begin
        strobe.loadCas = 1'b1;
        phaseNext      = PH_CAS;
      end
      PH_CAS: if (phaseDone) begin
        strobe.loadRas = 1'b1;
        phaseNext      = PH_RAS;
      end
      PH_RAS: if (phaseDone) begin
        strobe.loadPre = 1'b1;
        phaseNext      = PH_PRE;
      end
      PH_PRE: if (phaseDone) begin
        strobe.cycleDone = 1'b1;
        phaseNext        = PH_IDLE;
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) phase <= PH_IDLE;
    else          phase <= phaseNext;
  end

  assign casN      = !((phase == PH_CAS) || (phase == PH_RAS));
  assign rasN      = !(phase == PH_RAS);
  assign refActive = (phase != PH_IDLE);
  assign refReq    = refreshEn && pendingNz && (phase == PH_IDLE);

  // Checks
  AST_CAS_BEFORE_RAS: assert property (@(posedge clk) disable iff (!porRstN)
    $fell(rasN) |-> (!casN && !$past(casN))); // R1

  AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!porRstN)
    ((phase == PH_IDLE) && (busBusy || !refGrant)) |=> (phase == PH_IDLE)); // R4

  AST_STROBES_OFF_AT_END: assert property (@(posedge clk) disable iff (!porRstN)
    strobe.cycleDone |=> (rasN && casN)); // R5

  AST_DISABLE_NO_START: assert property (@(posedge clk) disable iff (!porRstN)
    (!refreshEn && (phase == PH_IDLE)) |=> (phase == PH_IDLE)); // R8

endmodule

// File: rtl/cbrRefreshSched.sv
module cbrRefreshSched
  import cbrRefreshPkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int TIME_W   = 4,
  parameter int MAX_PEND = 7,
  localparam int PEND_W  = $clog2(MAX_PEND + 1)
) (
  input  logic                clk,
  input  logic                porRstN,
  input  logic                extRst,
  input  logic                refreshEn,
  input  logic [PERIOD_W-1:0] periodCfg,
  input  logic [TIME_W-1:0]   casSetupCfg,
  input  logic [TIME_W-1:0]   rasWidthCfg,
  input  logic [TIME_W-1:0]   prechargeCfg,
  input  logic                busBusy,
  input  logic                refGrant,
  output logic                refReq,
  output logic                refActive,
  output logic                rasN,
  output logic                casN,
  output logic [PEND_W-1:0]   pendingCnt,
  output logic                overflow
);

  ctlStrobeT strobe;
  logic      pendingNz;
  logic      phaseDone;

  cbrRefreshData #(
    .PERIOD_W (PERIOD_W),
    .TIME_W   (TIME_W),
    .MAX_PEND (MAX_PEND)
  ) u_data (
    .clk          (clk),
    .porRstN      (porRstN),
    .extRst       (extRst),
    .refreshEn    (refreshEn),
    .periodCfg    (periodCfg),
    .casSetupCfg  (casSetupCfg),
    .rasWidthCfg  (rasWidthCfg),
    .prechargeCfg (prechargeCfg),
    .strobe       (strobe),
    .pendingCnt   (pendingCnt),
    .pendingNz    (pendingNz),
    .phaseDone    (phaseDone),
    .overflow     (overflow)
  );

  cbrRefreshCtl u_ctl (
    .clk       (clk),
    .porRstN   (porRstN),
    .refreshEn (refreshEn),
    .pendingNz (pendingNz),
    .phaseDone (phaseDone),
    .refGrant  (refGrant),
    .busBusy   (busBusy),
    .strobe    (strobe),
    .refReq    (refReq),
    .refActive (refActive),
    .rasN      (rasN),
    .casN      (casN)
  );

endmodule

// File: tb/cbrRefreshSched_bench.sv
module cbrRefreshSched_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        porRstN, extRst, refreshEn, busBusy, refGrant;
  logic [15:0] periodCfg;
  logic [3:0]  casSetupCfg, rasWidthCfg, prechargeCfg;
  logic        refReq, refActive, rasN, casN, overflow;
  logic [2:0]  pendingCnt;

  int nCmp = 0;
  int nBad = 0;
  int cyc  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbrRefreshSched u_cbrRefreshSched (
    .clk          (clk),
    .porRstN      (porRstN),
    .extRst       (extRst),
    .refreshEn    (refreshEn),
    .periodCfg    (periodCfg),
    .casSetupCfg  (casSetupCfg),
    .rasWidthCfg  (rasWidthCfg),
    .prechargeCfg (prechargeCfg),
    .busBusy      (busBusy),
    .refGrant     (refGrant),
    .refReq       (refReq),
    .refActive    (refActive),
    .rasN         (rasN),
    .casN         (casN),
    .pendingCnt   (pendingCnt),
    .overflow     (overflow)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int mTimer, mPend, mPh, mRem;
  bit mOvf;

  function automatic int lenOf(input int v);
    return (v == 0) ? 0 : v - 1;
  endfunction

  always @(posedge clk) begin
    bit tk, dn, dec, inc;
    cyc++;
    if (!porRstN) begin
      mTimer = 0; mPend = 0; mPh = 0; mRem = 0; mOvf = 0;
    end else begin
      tk = refreshEn && (mTimer + 1 >= int'(periodCfg));
      dn = 0;
      if (mPh == 0) begin
        if (refreshEn && mPend > 0 && refGrant && !busBusy) begin
          mPh = 1; mRem = lenOf(int'(casSetupCfg));
        end
      end else if (mRem > 0) begin
        mRem--;
      end else if (mPh == 1) begin
        mPh = 2; mRem = lenOf(int'(rasWidthCfg));
      end else if (mPh == 2) begin
        mPh = 3; mRem = lenOf(int'(prechargeCfg));
      end else begin
        mPh = 0; dn = 1;
      end
      if (!refreshEn) begin
        mPend = 0;
      end else begin
        dec = dn && (mPend > 0);
        inc = tk && ((mPend < 7) || dec);
        if (tk && !inc) mOvf = 1;
        else if (extRst) mOvf = 0;
        mPend = mPend + int'(inc) - int'(dec);
      end
      if (!refreshEn && extRst) mOvf = 0;
      mTimer = (!refreshEn || tk) ? 0 : mTimer + 1;
    end
    #2;
    chk(casN == !(mPh == 1 || mPh == 2), "R1", "casN", int'(casN), int'(!(mPh == 1 || mPh == 2)));
    chk(rasN == !(mPh == 2), "R5", "rasN", int'(rasN), int'(!(mPh == 2)));
    chk(refActive == (mPh != 0), "R5", "refActive", int'(refActive), int'(mPh != 0));
    chk(refReq == (refreshEn && mPend > 0 && mPh == 0), "R4", "refReq",
        int'(refReq), int'(refreshEn && mPend > 0 && mPh == 0));
    chk(int'(pendingCnt) == mPend, "R2", "pendingCnt", int'(pendingCnt), mPend);
    chk(overflow == mOvf, "R3", "overflow", int'(overflow), int'(mOvf));
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > WDOG) begin
      nBad++;
      $display("FAIL R4 watchdog expired: actual %0d expected %0d", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic randomRun(input int n);
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      busBusy  = lfsr[0] & lfsr[1];
      refGrant = lfsr[2] | lfsr[3];
    end
  endtask

  initial begin
    porRstN = 1'b0; extRst = 1'b0; refreshEn = 1'b0;
    periodCfg = 16'd10; casSetupCfg = 4'd2; rasWidthCfg = 4'd3; prechargeCfg = 4'd2;
    busBusy = 1'b0; refGrant = 1'b1;
    waitClk(3);
    // R9: reset state
    chk(rasN && casN, "R9", "strobes in reset", int'({rasN, casN}), 3);
    chk(!refReq && !refActive, "R9", "req/active in reset", int'({refReq, refActive}), 0);
    chk(pendingCnt == 0 && !overflow, "R9", "pend/ovf in reset", int'(pendingCnt), 0);
    porRstN = 1'b1;

    // R2, R1, R5: regular service with free bus
    refreshEn = 1'b1;
    waitClk(150);

    // R3: bus withheld, backlog saturates
    refGrant = 1'b0; periodCfg = 16'd3;
    waitClk(40);
    chk(pendingCnt == 3'd7, "R3", "saturated backlog", int'(pendingCnt), 7);
    chk(overflow, "R3", "overflow set", int'(overflow), 1);

    // R7: drain while external reset is held
    periodCfg = 16'd40; refGrant = 1'b1; extRst = 1'b1;
    waitClk(20);
    chk(!overflow, "R7", "overflow cleared by extRst", int'(overflow), 0);
    chk(pendingCnt < 3'd7, "R7", "refresh served under extRst", int'(pendingCnt), 5);
    extRst = 1'b0;

    // R4, R6: random grant and busy
    periodCfg = 16'd12;
    randomRun(1500);

    // R5: minimum phases, tick every clock
    busBusy = 1'b0; refGrant = 1'b1;
    casSetupCfg = 4'd0; rasWidthCfg = 4'd0; prechargeCfg = 4'd0; periodCfg = 16'd1;
    waitClk(60);
    chk(overflow, "R3", "overflow under period one", int'(overflow), 1);

    // R8: disable in the middle of a cycle
    casSetupCfg = 4'd3; rasWidthCfg = 4'd4; prechargeCfg = 4'd3; periodCfg = 16'd5;
    waitClk(10);
    while (!refActive || rasN) @(negedge clk);
    refreshEn = 1'b0;
    waitClk(1);
    chk(pendingCnt == 0, "R8", "backlog cleared", int'(pendingCnt), 0);
    chk(refActive, "R8", "running cycle continues", int'(refActive), 1);
    waitClk(15);
    chk(!refActive && !refReq, "R8", "no new cycle", int'({refActive, refReq}), 0);
    chk(rasN && casN && pendingCnt == 0, "R8", "quiet when disabled", int'(pendingCnt), 0);

    // R2, R6: re-enable with other timings
    refreshEn = 1'b1; periodCfg = 16'd7;
    casSetupCfg = 4'd1; rasWidthCfg = 4'd2; prechargeCfg = 4'd1;
    randomRun(500);

    waitClk(2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule